// File: doc/BRIEF.md
# Clock-Gated Control Sequencer with Self-Loop Detection

This block is a five-state Moore control machine that sequences a transfer: it rests until told to go, prepares until it gets an acknowledge or is aborted, runs until halted, then spends one cycle flushing and one cycle finishing. The state register does not see the free-running clock. It sees a qualified clock produced by a latch-and-AND gating cell.

An activation detector looks at the present state and the inputs. It flags the cycles in which the machine would stay in its current state. Because the machine is Moore, its outputs would then also stay the same. The flag is captured by a latch that is open only while the clock is low. A low enable keeps the qualified clock at zero for that whole cycle. A parameter chooses which of the three self-looping states the detector covers. This trades detector logic against the number of edges that are saved.

The latched enable is brought out for test. Seen from its ports, the block behaves cycle for cycle like the same machine clocked on every edge.

Top module: `cg_fsm_top`

## Requirements
- R1: While rst_n is low the machine is in Rest, and `out_vec` reads 3'b000.
- R2: Input bits are go = `in_vec[0]`, halt = `in_vec[1]` and ack = `in_vec[2]`. The transitions are:
  - Rest goes to Prep on go, and otherwise stays in Rest.
  - In Prep, halt has priority and returns the machine to Rest. Otherwise ack moves it to Run, and with neither bit it stays in Prep.
  - Run goes to Flush on halt, and otherwise stays in Run.
  - Flush always goes to Finish.
  - Finish goes to Prep on go, and otherwise to Rest.
- R3: The Moore outputs are Rest = 000, Prep = 001, Run = 011, Flush = 101 and Finish = 100.
- R4: In a covered state with a self-loop condition present, `clk_en_o` is 0 during that cycle's low phase. Otherwise it is 1. Each low enable removes exactly one state-register edge.
- R5: `clk_en_o` changes only while clk is low, and the qualified clock is never high while clk is low.
- R6: While the enable is low the state does not change across the suppressed edge.
- R7: `out_vec` equals that of an always-clocked copy of the same machine on every cycle, including the cycle that ends an idle stretch.
- R8: `IDLE_COVER` bit 0 covers Rest, bit 1 covers Prep and bit 2 covers Run. A state whose bit is 0 is never gated.
- R9: While rst_n is low, `clk_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vec | input | 3 | Control inputs: go, halt, ack |
| out_vec | output | 3 | Moore outputs of the present state |
| clk_en_o | output | 1 | Latched clock enable, for test |

## Verification
- **Input timing:** Inputs change 1 ns after a rising edge.
- **Enable:** The enable decision for the next edge is due during the following low phase. The bench samples it 3 ns after the rising edge, when the latch is transparent and has settled.
- **Outputs:** The outputs move only on the qualified edge after the one on which an input was seen. The bench advances its ungated model on that same edge and compares at the same 3 ns point.
- **Suppressed edges:** Counts of low enables over constant-input stretches are compared against the number of cycles the model spends in a covered self-loop.

// File: rtl/cg_fsm_pkg.sv
package cg_fsm_pkg;

    localparam int IN_W   = 3;
    localparam int OUT_W  = 3;
    localparam int LOOP_N = 3;
    localparam int ST_W   = 3;

    localparam int IN_GO   = 0;
    localparam int IN_HALT = 1;
    localparam int IN_ACK  = 2;

    typedef enum logic [ST_W-1:0] {
        ST_REST  = 3'd0,
        ST_PREP  = 3'd1,
        ST_RUN   = 3'd2,
        ST_FLUSH = 3'd3,
        ST_FIN   = 3'd4
    } ctl_state_t;

    // Coverage slot of a self-looping state; LOOP_N means "no slot".
    function automatic int loop_slot(input ctl_state_t s);
        case (s)
            ST_REST: return 0;
            ST_PREP: return 1;
            ST_RUN:  return 2;
            default: return LOOP_N;
        endcase
    endfunction

endpackage

// File: rtl/cg_fsm_next.sv
module cg_fsm_next
    import cg_fsm_pkg::*;
(
    input  ctl_state_t        cur,
    input  logic [IN_W-1:0]   in_vec,
    output ctl_state_t        nxt
);

    logic go, halt, ack;

    assign go   = in_vec[IN_GO];
    assign halt = in_vec[IN_HALT];
    assign ack  = in_vec[IN_ACK];

    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_REST:  nxt = go ? ST_PREP : ST_REST;
            ST_PREP:  begin
                if (halt)     nxt = ST_REST;
                else if (ack) nxt = ST_RUN;
                else          nxt = ST_PREP;
            end
            ST_RUN:   nxt = halt ? ST_FLUSH : ST_RUN;
            ST_FLUSH: nxt = ST_FIN;
            ST_FIN:   nxt = go ? ST_PREP : ST_REST;
            default:  nxt = ST_REST;
        endcase
    end

endmodule

// File: rtl/cg_idle_detect.sv
module cg_idle_detect
    import cg_fsm_pkg::*;
#(
    parameter logic [LOOP_N-1:0] IDLE_COVER = '1
) (
    input  ctl_state_t cur,
    input  ctl_state_t nxt,
    output logic       idle
);

    logic            self_loop;
    logic [LOOP_N-1:0] slot_hit;

    assign self_loop = (nxt == cur);

    // One detector term per self-looping state; uncovered slots are tied off.
    for (genvar k = 0; k < LOOP_N; k++) begin : g_slot
        if (IDLE_COVER[k]) begin : g_on
            assign slot_hit[k] = self_loop && (loop_slot(cur) == k);
        end else begin : g_off
            assign slot_hit[k] = 1'b0;
        end
    end

    assign idle = |slot_hit;

endmodule

// File: rtl/cg_clk_gate.sv
module cg_clk_gate (
    input  logic clk,
    input  logic en_req,
    output logic gclk,
    output logic en_lat
);

    // Transparent while clk is low; closed during the high phase.
    always_latch begin
        if (!clk) en_lat <= en_req;
    end

    assign gclk = clk & en_lat;

endmodule

// File: rtl/cg_fsm_top.sv
module cg_fsm_top
    import cg_fsm_pkg::*;
#(
    parameter logic [LOOP_N-1:0] IDLE_COVER = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  in_vec,
    output logic [OUT_W-1:0] out_vec,
    output logic             clk_en_o
);

    ctl_state_t state_q;
    ctl_state_t state_d;
    logic       idle;
    logic       en_req;
    logic       gclk;

    cg_fsm_next u_next (
        .cur    (state_q),
        .in_vec (in_vec),
        .nxt    (state_d)
    );

    cg_idle_detect #(.IDLE_COVER(IDLE_COVER)) u_idle (
        .cur  (state_q),
        .nxt  (state_d),
        .idle (idle)
    );

    // Reset keeps the enable open so the register sees edges once released.
    assign en_req = ~idle | ~rst_n;

    cg_clk_gate u_gate (
        .clk    (clk),
        .en_req (en_req),
        .gclk   (gclk),
        .en_lat (clk_en_o)
    );

    always_ff @(posedge gclk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_REST;
        else        state_q <= state_d;
    end

    always_comb begin
        out_vec = '0;
        unique case (state_q)
            ST_REST:  out_vec = 3'b000;
            ST_PREP:  out_vec = 3'b001;
            ST_RUN:   out_vec = 3'b011;
            ST_FLUSH: out_vec = 3'b101;
            ST_FIN:   out_vec = 3'b100;
            default:  out_vec = 3'b000;
        endcase
    end

endmodule

// File: rtl/cg_fsm_checker.sv
module cg_fsm_checker
    import cg_fsm_pkg::*;
#(
    parameter logic [LOOP_N-1:0] IDLE_COVER = '1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IN_W-1:0]  in_vec,
    input logic [OUT_W-1:0] out_vec,
    input logic             clk_en_o,
    input logic             gclk,
    input ctl_state_t       state_q
);

    // R1, R9: reset state and open enable
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_out_R1: assert (out_vec == 3'b000 && state_q == ST_REST)
                else $error("reset state wrong");
            assert_reset_en_R9: assert (clk_en_o == 1'b1)
                else $error("enable closed in reset");
        end
    end

    // R5: qualified clock never high in the low phase
    always @(gclk) begin
        if (rst_n && gclk) begin
            assert_gclk_in_high_R5: assert (clk == 1'b1)
                else $error("qualified clock high while clk low");
        end
    end

    // R5: enable only moves during the low phase
    always @(clk_en_o) begin
        if (rst_n) begin
            assert_en_low_phase_R5: assert (clk == 1'b0)
                else $error("enable changed while clk high");
        end
    end

    assert_rest_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REST && in_vec[IN_GO]) |=> (state_q == ST_PREP));

    assert_run_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && in_vec[IN_HALT]) |=> (state_q == ST_FLUSH));

    assert_flush_fin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> (state_q == ST_FIN));

    assert_gated_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_o) |=> $stable(state_q));

    assert_uncovered_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((loop_slot(state_q) == 0 && !IDLE_COVER[0]) ||
         (loop_slot(state_q) == 1 && !IDLE_COVER[1]) ||
         (loop_slot(state_q) == 2 && !IDLE_COVER[2])) |-> clk_en_o);

endmodule

bind cg_fsm_top cg_fsm_checker #(.IDLE_COVER(IDLE_COVER)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vec   (in_vec),
    .out_vec  (out_vec),
    .clk_en_o (clk_en_o),
    .gclk     (gclk),
    .state_q  (state_q)
);

// File: tb/tb_cg_fsm_top.sv
`timescale 1ns/1ps
module tb_cg_fsm_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] in_vec = 3'b000;
    logic [2:0] out_full, out_part;
    logic       en_full, en_part;

    int checks = 0;
    int fails  = 0;
    int sup_exp = 0;
    int sup_obs = 0;
    bit done = 0;

    int rs = 0;           // model state: 0 rest,1 prep,2 run,3 flush,4 fin
    logic [2:0] cur_in = 3'b000;

    always #2 clk = ~clk;   // 250 MHz

    cg_fsm_top dut (
        .clk(clk), .rst_n(rst_n), .in_vec(in_vec),
        .out_vec(out_full), .clk_en_o(en_full)
    );

    cg_fsm_top #(.IDLE_COVER(3'b011)) dut_part (
        .clk(clk), .rst_n(rst_n), .in_vec(in_vec),
        .out_vec(out_part), .clk_en_o(en_part)
    );

    function automatic int m_next(input int s, input logic [2:0] v);
        case (s)
            0: return v[0] ? 1 : 0;
            1: return v[1] ? 0 : (v[2] ? 2 : 1);
            2: return v[1] ? 3 : 2;
            3: return 4;
            default: return v[0] ? 1 : 0;
        endcase
    endfunction

    function automatic logic [2:0] m_out(input int s);
        case (s)
            0: return 3'b000;
            1: return 3'b001;
            2: return 3'b011;
            3: return 3'b101;
            default: return 3'b100;
        endcase
    endfunction

    function automatic logic m_en(input int s, input logic [2:0] v, input logic [2:0] cov);
        if (s <= 2 && m_next(s, v) == s && cov[s]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive a new input 1 ns after an edge, compare 3 ns after the edge.
    task automatic step(input logic [2:0] v);
        @(posedge clk);
        rs = m_next(rs, cur_in);
        #1;
        in_vec = v;
        cur_in = v;
        #2;
        chk("R3/R7 outputs full", {1'b0, out_full}, {1'b0, m_out(rs)});
        chk("R7 outputs partial", {1'b0, out_part}, {1'b0, m_out(rs)});
        chk("R4 enable full", {3'b0, en_full}, {3'b0, m_en(rs, v, 3'b111)});
        chk("R8 enable partial", {3'b0, en_part}, {3'b0, m_en(rs, v, 3'b011)});
        if (!m_en(rs, v, 3'b111)) sup_exp++;
        if (!en_full) sup_obs++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int s0;
        void'($urandom(32'd1234));

        // R1 / R9: reset state
        repeat (3) @(posedge clk);
        #3;
        chk("R1 reset out", {1'b0, out_full}, 4'b0000);
        chk("R9 reset enable", {3'b0, en_full}, 4'b0001);
        chk("R9 reset enable partial", {3'b0, en_part}, 4'b0001);
        @(posedge clk);
        #1 rst_n = 1'b1;
        rs = 0;
        cur_in = 3'b000;

        // R4: constant idle stretch in Rest -> 8 suppressed edges
        s0 = sup_obs;
        for (int i = 0; i < 8; i++) step(3'b000);
        chk("R4 rest stretch suppressed", 4'(sup_obs - s0), 4'd8);

        // go -> Prep, then wait in Prep (gated), then ack -> Run
        step(3'b001);
        for (int i = 0; i < 4; i++) step(3'b000);
        chk("R2 in prep", {1'b0, out_full}, 4'b0001);
        step(3'b100);

        // Run stretch: full gates, partial (Run uncovered) stays open, R8
        s0 = sup_obs;
        for (int i = 0; i < 6; i++) step(3'b000);
        chk("R4 run stretch suppressed", 4'(sup_obs - s0), 4'd6);
        chk("R8 run uncovered open", {3'b0, en_part}, 4'b0001);
        chk("R6 run held", {1'b0, out_full}, 4'b0011);

        // halt -> Flush -> Finish, with go on Finish -> Prep (R2)
        step(3'b010);
        step(3'b000);
        chk("R2 flush", {1'b0, out_full}, 4'b0101);
        step(3'b001);
        chk("R2 finish", {1'b0, out_full}, 4'b0100);
        step(3'b000);
        chk("R2 finish to prep", {1'b0, out_full}, 4'b0001);

        // Prep with halt and ack together: halt wins, back to Rest (R2)
        step(3'b110);
        step(3'b000);
        chk("R2 halt priority", {1'b0, out_full}, 4'b0000);

        // Random stimulus
        for (int i = 0; i < 600; i++) begin
            logic [2:0] v;
            v[0] = ($urandom % 4) == 0;
            v[1] = ($urandom % 7) == 0;
            v[2] = ($urandom % 3) == 0;
            if (($urandom % 5) == 0) v = cur_in;
            step(v);
        end

        chk("R4 total suppressed count", 4'(sup_obs == sup_exp), 4'd1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule